// File: doc/BRIEF.md
# Single-Source Interrupt Mask Controller

This block is a small byte-wide register-mapped interrupt controller for one interrupt line raised by user logic. The raw line is brought into the bus clock domain through a synchronizer. It then feeds one status bit. A mode bit decides how that status bit behaves. In edge mode a rising edge of the source sets the status, and the status stays set until software writes a clear. In level mode the status simply follows the synchronized source.

A mask bit gates the status onto an active-low interrupt line toward the bus bridge. Software sets the mask through one register offset and clears it through another, and both offsets read back the mask. The status can be read at any time, whatever the mask holds. After reset the mask is set, so no interrupt reaches the bridge until software clears it.

Register offsets used by software: 2 sets the mask, 3 clears the mask, 4 holds the status (in edge mode, writing 1 here clears it), and 6 holds the mode bit. In every register only bit 0 carries meaning.

Top module: `irq_mask_ctl`

## Requirements
- R1: Only bit 0 of write data acts. A write of 0x00 to offsets 2, 3 or 4 changes nothing. Every read returns 0 in bits 7..1, and an unmapped offset reads 0x00.
- R2: A write with bit 0 = 1 to offset 2 sets the mask. A write with bit 0 = 1 to offset 3 clears it. Reads at offset 2 and at offset 3 both return the mask in bit 0.
- R3: After reset the mask is 1, the mode bit is 0 (edge), the status is 0 and irqOutN is 1.
- R4: The status reads at offset 4, bit 0, with the same value whether the mask is set or clear.
- R5: In edge mode (mode bit 0) a rising edge of the source sets the status. The status stays set after the source falls, until a write with bit 0 = 1 to offset 4 clears it.
- R6: In edge mode, a rising edge that reaches the status logic in the same cycle as a status-clear write wins, and the status stays set.
- R7: In level mode (mode bit 1) the status equals the synchronized source. A write to offset 4 has no effect on it, and it clears only when the source goes low.
- R8: irqOutN is 0 exactly when the status is 1 and the mask is 0. Otherwise it is 1.
- R9: The mode bit is written and read at offset 6, bit 0. A value of 1 selects level mode.
- R10: A change of srcIrq appears in the status on the third rising clock edge after it is applied, and not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register offset for both reads and writes |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data; bits 7..1 must be zero |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| srcIrq | input | 1 | Raw interrupt source, asynchronous to clk |
| irqOutN | output | 1 | Active-low interrupt toward the bridge |

## Verification
On every cycle the embedded assertions check five things. A set write leaves the mask set and a clear write leaves it clear. The mask is set on the first cycle after reset. In level mode the status tracks the synchronized source. In edge mode a synchronized rising edge always leaves the status set, even against a clear, and the status holds when no edge and no clear arrive. The output is never low while the mask is set. Other properties need the bench's scenarios, because they involve the register interface or timing at the ports. These are the three-edge synchronizer latency measured at the ports, the readback values and their zero upper bits, the lack of effect of zero-data writes, the survival of a latched status after the source falls, and the full mode-by-mask-by-source sweep of the output.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 4'd3;
  localparam logic [ADDR_W-1:0] OFS_STATUS   = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_MODE     = 4'd6;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_MASK,
    RD_STATUS,
    RD_MODE
  } rdSel_e;

  typedef struct packed {
    logic   maskSet;
    logic   maskClr;
    logic   statClr;
    logic   modeWr;
    logic   modeVal;
    rdSel_e rdSel;
  } irqStrobe_t;
endpackage

// File: rtl/irq_mask_decode.sv
module irq_mask_decode
  import irq_mask_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output irqStrobe_t        stb
);
  logic bitZero;
  logic hitSet, hitClr, hitStat, hitMode;

  assign bitZero = regWrData[0];
  assign hitSet  = (regAddr == OFS_MASK_SET);
  assign hitClr  = (regAddr == OFS_MASK_CLR);
  assign hitStat = (regAddr == OFS_STATUS);
  assign hitMode = (regAddr == OFS_MODE);

  always_comb begin
    stb         = '0;
    stb.maskSet = regWrEn && hitSet && bitZero;
    stb.maskClr = regWrEn && hitClr && bitZero;
    stb.statClr = regWrEn && hitStat && bitZero;
    stb.modeWr  = regWrEn && hitMode;
    stb.modeVal = bitZero;
    if (hitSet || hitClr)  stb.rdSel = RD_MASK;
    else if (hitStat)      stb.rdSel = RD_STATUS;
    else if (hitMode)      stb.rdSel = RD_MODE;
    else                   stb.rdSel = RD_NONE;
  end

  // R1: software keeps reserved write bits at zero
  mbz_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regWrData[DATA_W-1:1] == '0));

  // R2: at most one mask strobe per cycle
  one_mask_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.maskSet && stb.maskClr));
endmodule

// File: rtl/irq_mask_datapath.sv
module irq_mask_datapath
  import irq_mask_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              srcIrq,
  input  irqStrobe_t        stb,
  output logic [DATA_W-1:0] rdData,
  output logic              irqActive
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic syncOut, prevQ, riseDet;
  logic maskQ, modeQ, statusQ;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= srcIrq;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], srcIrq};
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];
  assign riseDet = syncOut && !prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ   <= 1'b0;
      maskQ   <= 1'b1;
      modeQ   <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      prevQ <= syncOut;
      if (stb.maskSet)      maskQ <= 1'b1;
      else if (stb.maskClr) maskQ <= 1'b0;
      if (stb.modeWr) modeQ <= stb.modeVal;
      if (modeQ)            statusQ <= syncOut;
      else if (riseDet)     statusQ <= 1'b1;
      else if (stb.statClr) statusQ <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (stb.rdSel)
      RD_MASK:   rdData[0] = maskQ;
      RD_STATUS: rdData[0] = statusQ;
      RD_MODE:   rdData[0] = modeQ;
      default:   rdData    = '0;
    endcase
  end

  assign irqActive = statusQ && !maskQ;

  // R3
  mask_after_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (maskQ && !statusQ && !modeQ));
  // R2
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.maskSet |=> maskQ);
  // R2
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.maskClr && !stb.maskSet) |=> !maskQ);
  // R7
  level_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeQ |=> (statusQ == $past(syncOut)));
  // R6
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ && riseDet) |=> statusQ);
  // R5
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ && !stb.modeWr && statusQ && !stb.statClr) |=> statusQ);
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_mask_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              srcIrq,
  output logic              irqOutN
);
  irqStrobe_t stb;
  logic irqActive;

  irq_mask_decode u_decode (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .stb(stb)
  );

  irq_mask_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .stb(stb),
    .rdData(regRdData), .irqActive(irqActive)
  );

  assign irqOutN = !irqActive;

  // R8
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == OFS_MASK_SET && regRdData[0]) |-> irqOutN);
endmodule

// File: tb/irq_mask_ctl_test.sv
`timescale 1ns/1ps
module irq_mask_ctl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic srcIrq = 1'b0;
  logic irqOutN;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_mask_ctl uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .srcIrq(srcIrq),
    .irqOutN(irqOutN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  task automatic setSrc(input logic v);
    @(negedge clk);
    srcIrq = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R3 reset state
    rd(4'd2, d); chk("R3 mask", d, 8'h01);
    rd(4'd6, d); chk("R3 mode", d, 8'h00);
    rd(4'd4, d); chk("R3 status", d, 8'h00);
    chk("R3 irqOutN", {7'b0, irqOutN}, 8'h01);
    // R1 unmapped offsets read zero
    for (int a = 0; a < 16; a++) begin
      if (a != 2 && a != 3 && a != 4 && a != 6) begin
        rd(a[3:0], d); chk("R1 unmapped", d, 8'h00);
      end
    end
    // R2 clear and set mask, read back at both offsets
    wr(4'd3, 8'h01);
    rd(4'd2, d); chk("R2 clr@2", d, 8'h00);
    rd(4'd3, d); chk("R2 clr@3", d, 8'h00);
    wr(4'd2, 8'h00);
    rd(4'd3, d); chk("R1 zero set ignored", d, 8'h00);
    wr(4'd2, 8'h01);
    rd(4'd3, d); chk("R2 set@3", d, 8'h01);
    wr(4'd3, 8'h00);
    rd(4'd2, d); chk("R1 zero clr ignored", d, 8'h01);
    // R10 latency, edge mode, mask clear
    wr(4'd3, 8'h01);
    @(negedge clk); srcIrq = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd4, d); chk("R10 not yet", d, 8'h00);
    chk("R10 out idle", {7'b0, irqOutN}, 8'h01);
    @(negedge clk);
    rd(4'd4, d); chk("R10 third edge", d, 8'h01);
    chk("R8 out low", {7'b0, irqOutN}, 8'h00);
    // R5 latch survives source fall
    setSrc(1'b0);
    rd(4'd4, d); chk("R5 held", d, 8'h01);
    wr(4'd4, 8'h00);
    rd(4'd4, d); chk("R1 zero status write ignored", d, 8'h01);
    // R4 status readable while masked
    wr(4'd2, 8'h01);
    rd(4'd4, d); chk("R4 masked status", d, 8'h01);
    chk("R8 masked high", {7'b0, irqOutN}, 8'h01);
    wr(4'd4, 8'h01);
    rd(4'd4, d); chk("R5 cleared", d, 8'h00);
    // R6 edge and clear in same cycle: status set first
    setSrc(1'b1);
    setSrc(1'b0);
    rd(4'd4, d); chk("R6 pre", d, 8'h01);
    @(negedge clk); srcIrq = 1'b1;
    repeat (2) @(negedge clk);
    regAddr = 4'd4; regWrData = 8'h01; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    rd(4'd4, d); chk("R6 edge wins", d, 8'h01);
    setSrc(1'b0);
    wr(4'd4, 8'h01);
    rd(4'd4, d); chk("R6 later clear", d, 8'h00);
    // R9 and R7 level mode
    wr(4'd6, 8'h01);
    rd(4'd6, d); chk("R9 mode readback", d, 8'h01);
    setSrc(1'b1);
    rd(4'd4, d); chk("R7 follows high", d, 8'h01);
    wr(4'd4, 8'h01);
    rd(4'd4, d); chk("R7 clear ignored", d, 8'h01);
    setSrc(1'b0);
    rd(4'd4, d); chk("R7 follows low", d, 8'h00);
    // Sweep mode x mask x source
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 2; k++) begin
        for (int s = 0; s < 2; s++) begin
          logic expSt, expOut;
          wr(4'd6, {7'b0, m[0]});
          setSrc(1'b0);
          wr(4'd4, 8'h01);
          if (k != 0) wr(4'd2, 8'h01); else wr(4'd3, 8'h01);
          setSrc(s[0]);
          expSt  = s[0];
          expOut = !(expSt && (k == 0));
          rd(4'd4, d); chk(m ? "R7 sweep status" : "R5 sweep status", d, {7'b0, expSt});
          chk("R8 sweep out", {7'b0, irqOutN}, {7'b0, expOut});
          rd(4'd2, d); chk("R2 sweep mask", d, {7'b0, k[0]});
        end
      end
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule